// File: doc/BRIEF.md
# Raster Video Timing Generator

This block sweeps a 1280x720 progressive raster from a 74.25 MHz pixel clock. It has two scan counters. A horizontal counter steps once per clock. A vertical counter steps once per finished line. Both counters wrap at the end of their range.

From the counter position, the block derives several outputs:
- the horizontal and vertical sync pulses, both active low;
- a data-enable flag;
- the column and row of the current pixel inside the visible area, for the pixel renderer that follows.

Each line has 1650 clocks. Its blanking interval comes first: a short porch, then the sync pulse, then the back porch. The visible pixels fill the last 1280 clocks of the line. The frame works the same way. It has 750 lines, and the 720 visible rows are the last ones.

All outputs come from registers loaded on the same edge, so each output always describes the same raster position. Every timing point is a parameter. Checks at elaboration reject orderings the block cannot produce.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst_n is low at a rising edge, the raster position is held at column count 0 and line 0. The outputs show that position: hsync_n=1, vsync_n=1, de=0, pix_x=0, pix_y=0. Reset is synchronous.
- R2: The horizontal count h runs 0,1,…,1649 and then returns to 0, one step per clock. This gives 1650 clocks per line.
- R3: hsync_n is 0 exactly for h in 110..149 and 1 for every other h.
- R4: The line count v steps by one only when h wraps from 1649 to 0. It runs 0..749 and then returns to 0 on the next line wrap.
- R5: vsync_n is 0 exactly for v in 5..9 and 1 on every other line.
- R6: de is 1 exactly when h is in 370..1649 and v is in 30..749, that is, when both axes are in their visible range.
- R7: pix_x equals h-370 while h is in 370..1649 and is 0 otherwise.
- R8: pix_y equals v-30 while v is in 30..749 and is 0 otherwise.
- R9: All outputs describe one position. After m rising edges with rst_n high following reset, the outputs show position m: h = m mod 1650, v = (m div 1650) mod 750.
- R10: Asserting reset at any point in the frame returns the outputs to the position-0 values of R1. After release, the scan restarts from position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_n | output | 1 | Horizontal sync, low during the pulse |
| vsync_n | output | 1 | Vertical sync, low during the pulse |
| de | output | 1 | High while the position is visible |
| pix_x | output | COORD_W (12) | Visible column, 0 outside the visible area |
| pix_y | output | COORD_W (12) | Visible row, 0 outside the visible rows |

## Verification
The assertions assume that the timing parameters keep the sync pulse inside the blanking interval and that blanking precedes the visible area on both axes. Under those assumptions, de can never overlap a sync pulse, and a run of visible pixels never crosses a line wrap. The only input is the reset, and the stimulus always drives it on the falling clock edge. Reset is applied once at the start of the run and once more in the middle of a frame, so every clocked property sees a clean boundary after release. The full-size timing is checked across the first forty lines. A second, reduced-parameter instance runs complete frames so that the frame wrap is reached.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;

   // width of a counter that holds values 0..n-1
   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // per-axis decode result
   typedef struct packed {
      logic sync_n;
      logic active;
   } axis_flags_t;

endpackage

// File: rtl/raster_scan_counter.sv
module raster_scan_counter
   import raster_timing_pkg::*;
#(
   parameter int TOTAL = 1650,
   localparam int W    = cnt_width(TOTAL)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [W-1:0] nxt_o
);

   logic [W-1:0] cnt_q;

   generate
      if ((1 << W) == TOTAL) begin : g_pow2
         // range fills the register: natural rollover
         assign nxt_o = step_i ? cnt_q + 1'b1 : cnt_q;
      end else begin : g_cmp
         logic at_end;
         assign at_end = (cnt_q == W'(TOTAL - 1));
         assign nxt_o  = step_i ? (at_end ? '0 : cnt_q + 1'b1) : cnt_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt_o;
   end

endmodule

// File: rtl/raster_axis_decode.sv
module raster_axis_decode
   import raster_timing_pkg::*;
#(
   parameter int TOTAL      = 1650,
   parameter int SYNC_START = 110,
   parameter int SYNC_END   = 150,
   parameter int ACT_START  = 370,
   parameter int CW         = 12,
   localparam int PW        = cnt_width(TOTAL)
) (
   input  logic [PW-1:0] pos_i,
   output axis_flags_t   flags_o,
   output logic [CW-1:0] coord_o
);

   int offset;

   always_comb begin
      flags_o.sync_n = !((pos_i >= PW'(SYNC_START)) && (pos_i < PW'(SYNC_END)));
      flags_o.active = (pos_i >= PW'(ACT_START));
      offset         = int'(pos_i) - ACT_START;
      coord_o        = flags_o.active ? CW'(offset) : '0;
   end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import raster_timing_pkg::*;
#(
   parameter int H_TOTAL      = 1650,
   parameter int H_SYNC_START = 110,
   parameter int H_SYNC_END   = 150,
   parameter int H_ACT_START  = 370,
   parameter int V_TOTAL      = 750,
   parameter int V_SYNC_START = 5,
   parameter int V_SYNC_END   = 10,
   parameter int V_ACT_START  = 30,
   parameter int COORD_W      = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               hsync_n,
   output logic               vsync_n,
   output logic               de,
   output logic [COORD_W-1:0] pix_x,
   output logic [COORD_W-1:0] pix_y
);

   localparam int HW = cnt_width(H_TOTAL);
   localparam int VW = cnt_width(V_TOTAL);

   // elaboration-time parameter checks
   generate
      if (!(H_SYNC_START > 0 && H_SYNC_START < H_SYNC_END &&
            H_SYNC_END <= H_ACT_START && H_ACT_START < H_TOTAL)) begin : g_bad_h
         $error("raster_timing_gen: horizontal timing points out of order");
      end
      if (!(V_SYNC_START > 0 && V_SYNC_START < V_SYNC_END &&
            V_SYNC_END <= V_ACT_START && V_ACT_START < V_TOTAL)) begin : g_bad_v
         $error("raster_timing_gen: vertical timing points out of order");
      end
      if ((H_TOTAL - H_ACT_START) > (1 << COORD_W) ||
          (V_TOTAL - V_ACT_START) > (1 << COORD_W)) begin : g_bad_w
         $error("raster_timing_gen: COORD_W too narrow for visible area");
      end
   endgenerate

   logic [HW-1:0]      h_nxt;
   logic [VW-1:0]      v_nxt;
   logic               h_wrap;
   axis_flags_t        h_flags, v_flags;
   logic [COORD_W-1:0] x_nxt, y_nxt;

   // the horizontal counter steps every clock, so a zero next value marks a wrap
   assign h_wrap = (h_nxt == '0);

   raster_scan_counter #(.TOTAL(H_TOTAL)) u_hcnt (
      .clk(clk), .rst_n(rst_n), .step_i(1'b1), .nxt_o(h_nxt)
   );

   raster_scan_counter #(.TOTAL(V_TOTAL)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .step_i(h_wrap), .nxt_o(v_nxt)
   );

   raster_axis_decode #(
      .TOTAL(H_TOTAL), .SYNC_START(H_SYNC_START), .SYNC_END(H_SYNC_END),
      .ACT_START(H_ACT_START), .CW(COORD_W)
   ) u_hdec (
      .pos_i(h_nxt), .flags_o(h_flags), .coord_o(x_nxt)
   );

   raster_axis_decode #(
      .TOTAL(V_TOTAL), .SYNC_START(V_SYNC_START), .SYNC_END(V_SYNC_END),
      .ACT_START(V_ACT_START), .CW(COORD_W)
   ) u_vdec (
      .pos_i(v_nxt), .flags_o(v_flags), .coord_o(y_nxt)
   );

   // outputs are loaded from the decode of the value the counters take on this edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hsync_n <= 1'b1;
         vsync_n <= 1'b1;
         de      <= 1'b0;
         pix_x   <= '0;
         pix_y   <= '0;
      end else begin
         hsync_n <= h_flags.sync_n;
         vsync_n <= v_flags.sync_n;
         de      <= h_flags.active && v_flags.active;
         pix_x   <= x_nxt;
         pix_y   <= y_nxt;
      end
   end

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
   import raster_timing_pkg::*;
#(
   parameter int H_TOTAL      = 1650,
   parameter int H_SYNC_START = 110,
   parameter int V_TOTAL      = 750,
   parameter int COORD_W      = 12,
   localparam int HW          = cnt_width(H_TOTAL),
   localparam int VW          = cnt_width(V_TOTAL)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               hsync_n,
   input logic               vsync_n,
   input logic               de,
   input logic [COORD_W-1:0] pix_x,
   input logic [COORD_W-1:0] pix_y,
   input logic [HW-1:0]      h_nxt,
   input logic [VW-1:0]      v_nxt
);

   // R2: wrap at the end of the line
   assert_h_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (h_nxt == HW'(H_TOTAL - 1)) |=> (h_nxt == '0));

   // R2: single step otherwise
   assert_h_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (h_nxt != HW'(H_TOTAL - 1)) |=> (h_nxt == $past(h_nxt) + 1'b1));

   // R3: the pulse begins at its programmed column
   assert_hsync_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hsync_n) |-> (h_nxt == HW'(H_SYNC_START + 1)));

   // R4: the line count moves only at a line wrap
   assert_v_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (h_nxt != '0) |-> $stable(v_nxt));

   // R5: vertical sync only changes at the start of a line
   assert_vsync_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vsync_n) |-> (h_nxt == HW'(1)));

   // R6: visible pixels never overlap a sync pulse
   assert_de_no_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (hsync_n && vsync_n));

   // R7: column advances by one along a visible run
   assert_x_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (de && $past(de)) |-> (pix_x == $past(pix_x) + 1'b1));

   // R8: row changes only at the start of a line
   assert_y_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pix_y) |-> (h_nxt == HW'(1)));

endmodule

bind raster_timing_gen raster_timing_chk #(
   .H_TOTAL(H_TOTAL), .H_SYNC_START(H_SYNC_START),
   .V_TOTAL(V_TOTAL), .COORD_W(COORD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
   .de(de), .pix_x(pix_x), .pix_y(pix_y), .h_nxt(h_nxt), .v_nxt(v_nxt)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   total = 0;
   int   bad = 0;
   int   cyc = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   // position counter kept by the bench: edges since reset release
   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   logic        d_hs, d_vs, d_de;
   logic [11:0] d_x, d_y;
   logic        s_hs, s_vs, s_de;
   logic [3:0]  s_x, s_y;

   raster_timing_gen u_dut (
      .clk(clk), .rst_n(rst_n), .hsync_n(d_hs), .vsync_n(d_vs),
      .de(d_de), .pix_x(d_x), .pix_y(d_y)
   );

   raster_timing_gen #(
      .H_TOTAL(16), .H_SYNC_START(2), .H_SYNC_END(4), .H_ACT_START(6),
      .V_TOTAL(8),  .V_SYNC_START(1), .V_SYNC_END(3), .V_ACT_START(4),
      .COORD_W(4)
   ) u_small (
      .clk(clk), .rst_n(rst_n), .hsync_n(s_hs), .vsync_n(s_vs),
      .de(s_de), .pix_x(s_x), .pix_y(s_y)
   );

   typedef struct packed {
      logic hs;
      logic vs;
      logic de;
      int   x;
      int   y;
   } exp_t;

   function automatic exp_t model(input int m, input int ht, input int hss, input int hse,
                                  input int has, input int vt, input int vss, input int vse,
                                  input int vas);
      exp_t e;
      int h = m % ht;
      int v = (m / ht) % vt;
      e.hs = !(h >= hss && h < hse);
      e.vs = !(v >= vss && v < vse);
      e.de = (h >= has) && (v >= vas);
      e.x  = (h >= has) ? h - has : 0;
      e.y  = (v >= vas) ? v - vas : 0;
      return e;
   endfunction

   task automatic one(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s at pos %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
      end
   endtask

   task automatic cmp(input string tag, input exp_t e, input logic hs, input logic vs,
                      input logic de, input int x, input int y);
      one({tag, "/R3"}, "hsync_n", int'(hs), int'(e.hs));
      one({tag, "/R5"}, "vsync_n", int'(vs), int'(e.vs));
      one({tag, "/R6"}, "de", int'(de), int'(e.de));
      one({tag, "/R7"}, "pix_x", x, e.x);
      one({tag, "/R8"}, "pix_y", y, e.y);
   endtask

   task automatic chk_default(input string tag);
      cmp(tag, model(cyc, 1650, 110, 150, 370, 750, 5, 10, 30),
          d_hs, d_vs, d_de, int'(d_x), int'(d_y));
   endtask

   task automatic chk_small(input string tag);
      cmp(tag, model(cyc, 16, 2, 4, 6, 8, 1, 3, 4),
          s_hs, s_vs, s_de, int'(s_x), int'(s_y));
   endtask

   // R1: reset holds position 0
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk_default("R1");
      chk_small("R1");
      rst_n = 1'b1;
   endtask

   // R2, R9: full-size line timing over the first forty lines
   task automatic t_scan_default();
      for (int i = 0; i < 40 * 1650 + 100; i++) begin
         chk_default("R9");
         if (cyc % 1650 == 1649) one("R2", "pix_x at line end", int'(d_x), 1279);
         if (cyc % 1650 == 0 && cyc > 0) one("R2", "de at line start", int'(d_de), 0);
         @(negedge clk);
      end
   endtask

   // R4: complete frames and frame wrap on the reduced instance
   task automatic t_frame_wrap();
      for (int i = 0; i < 3 * 128; i++) begin
         chk_small("R4");
         @(negedge clk);
      end
   endtask

   // R10: reset in the middle of a frame
   task automatic t_mid_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_default("R10");
      chk_small("R10");
      rst_n = 1'b1;
      for (int i = 0; i < 2000; i++) begin
         chk_default("R10");
         chk_small("R10");
         @(negedge clk);
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      @(negedge clk);
      t_scan_default();
      t_frame_wrap();
      t_mid_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule